// File: doc/BRIEF.md
# Completion Rate Monitor with Integral Speed Control

This block watches self-timed logic and closes a speed-control loop around it. Each completion strobe from the logic (or the monitored circuit's own clock) is brought into the local clock domain, edge-detected and counted. A measurement window spans a fixed number of rising edges of an external reference clock, fifty by default. At each window end the count is frozen and published, then compared with a programmable setpoint.

The count error (setpoint minus count) is scaled down by a programmable right shift and summed into a signed, saturating integrator once per window. The upper bits of the integrator, in offset binary, form the speed knob code for the monitored logic. A slow circuit (too few completions) pushes the knob up; a fast one pushes it down. Both asynchronous inputs pass through two-flop synchronisers, so the local clock must be well above both input rates.

Top module: `cmpl_rate_ctl`

## Requirements
- R1: Every rising edge on `cmpl_async` is counted once after a two-flop synchroniser, provided the input stays high and low for at least one `clk` period each. Holding it high for several cycles still counts one event.
- R2: A window closes on every DIV-th synchronised rising edge of `ref_async` (DIV = 50). Neither `last_count` nor `knob` changes between two closes.
- R3: When a window closes, `last_count` takes the number of completion events counted since the previous close. It holds that value until the next close.
- R4: One clock after each close, the integrator adds e = `target` − `last_count`, shifted arithmetically right by `gain_sh` bits (rounding toward minus infinity).
- R5: The integrator is a signed ACC_W-bit value that saturates at −2^(ACC_W−1) and 2^(ACC_W−1)−1 instead of wrapping.
- R6: `knob` is the top KNOB_W bits of the integrator with the sign bit inverted. Bit KNOB_W−1 of `knob` is the inverted sign, so zero maps to 2^(KNOB_W−1).
- R7: After reset the integrator is zero, `knob` equals 2^(KNOB_W−1) and `last_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmpl_async | input | 1 | Completion strobe from the monitored logic, asynchronous |
| ref_async | input | 1 | External reference clock, asynchronous |
| target | input | CNT_W | Setpoint: events wanted per window |
| gain_sh | input | SH_W | Right shift applied to the error |
| knob | output | KNOB_W | Speed knob code, offset binary |
| last_count | output | CNT_W | Event count of the last closed window |

## Verification
A wrong event counter or divider shows at `last_count` at the very next window close, as a count off from what was driven or as a change at the wrong reference edge. A wrong error, shift or integrator appears at `knob` one clock after that close. It may only become visible after several windows, when the integrator crosses a knob step or reaches a rail, so the bench follows long runs of windows toward both saturation limits. Knob and count are also sampled in the middle and at the end of each window to catch any change outside a close.

// File: rtl/cmpl_rate_ctl.sv
module cmpl_rate_ctl #(
  parameter int DIV    = 50,
  parameter int CNT_W  = 12,
  parameter int ACC_W  = 16,
  parameter int KNOB_W = 4,
  parameter int SH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmpl_async,
  input  logic              ref_async,
  input  logic [CNT_W-1:0]  target,
  input  logic [SH_W-1:0]   gain_sh,
  output logic [KNOB_W-1:0] knob,
  output logic [CNT_W-1:0]  last_count
);
  localparam int DW = $clog2(DIV);
  localparam int SW = ((CNT_W + 1 > ACC_W) ? CNT_W + 1 : ACC_W) + 1;
  localparam logic signed [SW-1:0] ACC_MAX = SW'((64'sd1 <<< (ACC_W - 1)) - 1);
  localparam logic signed [SW-1:0] ACC_MIN = -ACC_MAX - SW'(1);

  logic [2:0] c_sy, r_sy;
  logic [DW-1:0] ref_cnt;
  logic [CNT_W-1:0] ev_cnt;
  logic upd;
  logic signed [ACC_W-1:0] acc;
  logic signed [SW-1:0] err, err_sh, sum;

  wire c_pulse = c_sy[1] & ~c_sy[2];
  wire r_edge  = r_sy[1] & ~r_sy[2];
  wire win_end = r_edge && (ref_cnt == DW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_sy <= '0;
      r_sy <= '0;
    end else begin
      c_sy <= {c_sy[1:0], cmpl_async};
      r_sy <= {r_sy[1:0], ref_async};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         ref_cnt <= '0;
    else if (win_end)   ref_cnt <= '0;
    else if (r_edge)    ref_cnt <= ref_cnt + DW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ev_cnt     <= '0;
      last_count <= '0;
      upd        <= 1'b0;
    end else begin
      upd <= win_end;
      if (win_end) begin
        last_count <= ev_cnt;
        ev_cnt     <= CNT_W'(c_pulse);
      end else if (c_pulse && ev_cnt != '1) begin
        ev_cnt <= ev_cnt + CNT_W'(1);
      end
    end

  assign err    = $signed(SW'(target)) - $signed(SW'(last_count));
  assign err_sh = err >>> gain_sh;
  assign sum    = SW'(acc) + err_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      acc <= '0;
    else if (upd) begin
      if (sum > ACC_MAX)      acc <= ACC_W'(ACC_MAX);
      else if (sum < ACC_MIN) acc <= ACC_W'(ACC_MIN);
      else                    acc <= ACC_W'(sum);
    end

  assign knob = {~acc[ACC_W-1], acc[ACC_W-2 -: KNOB_W-1]};

  a_r1_single_count: assert property (@(posedge clk) disable iff (!rst_n)
    c_pulse |=> !c_pulse);
  a_r2_divider_range: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cnt <= DW'(DIV - 1));
  a_r3_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(last_count));
  a_r4_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && err_sh > 0) |=> acc >= $past(acc));
  a_r5_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && err_sh < 0) |=> acc <= $past(acc));
  a_r6_knob_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(knob));
endmodule

// File: tb/cmpl_rate_ctl_test.sv
`timescale 1ns/1ps
module cmpl_rate_ctl_test;
  localparam int CNT_W = 12, ACC_W = 12, KNOB_W = 4, SH_W = 4;

  logic clk = 0, rst_n = 0, cmpl_async = 0, ref_async = 0;
  logic [CNT_W-1:0] target = '0;
  logic [SH_W-1:0] gain_sh = '0;
  logic [KNOB_W-1:0] knob;
  logic [CNT_W-1:0] last_count;

  int n_chk = 0, n_bad = 0;
  int acc_m = 0, prev_n = 0, done = 0;

  cmpl_rate_ctl #(.DIV(50), .CNT_W(CNT_W), .ACC_W(ACC_W), .KNOB_W(KNOB_W), .SH_W(SH_W))
    uut (.clk, .rst_n, .cmpl_async, .ref_async, .target, .gain_sh, .knob, .last_count);

  always #5 clk = ~clk;

  function automatic int knob_m();
    return (acc_m + (1 << (ACC_W - 1))) >> (ACC_W - KNOB_W);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ref_period(input int ne);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      ref_async  = (c < 4);
      cmpl_async = (ne >= 1 && c == 1) || (ne >= 2 && (c == 5 || c == 6));
    end
  endtask

  // boundary period closes previous window; events go in periods 1..49
  task automatic run_window(input int n);
    int rem = n;
    int e, mx, mn;
    ref_period(0);
    e = int'(target) - prev_n;
    e = e >>> int'(gain_sh);
    acc_m = acc_m + e;
    mx = (1 << (ACC_W - 1)) - 1;
    mn = -(1 << (ACC_W - 1));
    if (acc_m > mx) acc_m = mx;
    if (acc_m < mn) acc_m = mn;
    check("R3 count at close", int'(last_count), prev_n);
    check("R4/R5/R6 knob after close", int'(knob), knob_m());
    for (int p = 1; p < 50; p++) begin
      int k = (rem > 2) ? 2 : rem;
      ref_period(k);
      rem -= k;
      if (p == 25 || p == 49) begin
        check("R2 count held mid-window", int'(last_count), prev_n);
        check("R2 knob held mid-window", int'(knob), knob_m());
      end
    end
    repeat (3) @(negedge clk);
    check("R2 no early close", int'(last_count), prev_n);
    prev_n = n;
  endtask

  task automatic t_reset();
    check("R7 reset knob", int'(knob), 1 << (KNOB_W - 1));
    check("R7 reset count", int'(last_count), 0);
    for (int p = 0; p < 49; p++) ref_period(0);
    check("R2 no close before 50th edge", int'(knob), 1 << (KNOB_W - 1));
  endtask

  task automatic t_basic();
    target = 12'd40; gain_sh = 0;
    run_window(40);
    run_window(30);
    run_window(60);
    run_window(40);
    run_window(97);
  endtask

  task automatic t_gain();
    target = 12'd40; gain_sh = 4'd3;
    run_window(5);
    run_window(60);
    run_window(98);
    gain_sh = 4'd1;
    run_window(41);
    run_window(0);
  endtask

  task automatic t_sat_hi();
    target = 12'd4000; gain_sh = 0;
    for (int w = 0; w < 3; w++) run_window(0);
    check("R5 upper rail knob", int'(knob), (1 << KNOB_W) - 1);
  endtask

  task automatic t_sat_lo();
    target = 12'd0; gain_sh = 0;
    for (int w = 0; w < 46; w++) run_window(98);
    check("R5 lower rail knob", int'(knob), 0);
    run_window(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_gain();
    t_sat_hi();
    t_sat_lo();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (done == 0) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule